// File: doc/BRIEF.md
# I2C SCL High/Low Period Generator

This block produces the SCL clock waveform of an I2C master. It times a low phase and a high phase by counting cycles of its own clock. A mode input chooses between a standard-mode pair of counts and a fast-mode pair. Each phase lasts its programmed count plus a fixed overhead. The low phase adds 1 cycle and begins in the first cycle the block pulls SCL down. The high phase adds 8 cycles. The high phase counts only cycles in which the sensed SCL line is really high, so a target that holds SCL low (clock stretching) lengthens the phase rather than cutting it short.

The bit engine beside the block uses two single-cycle strobes. The first marks the first cycle of each low phase, where SDA may change. The second marks the middle of the released-and-high window, where SDA is sampled. The counts and the mode select are captured only while the block is disabled. Any change to them during operation has no effect until the next disabled interval. Programmed counts below a legal minimum are raised to that minimum: 6 for a high count and 8 for a low count.

The controller has three states. IDLE releases SCL and captures the configuration. LOW drives SCL low. HIGH releases SCL and counts the high time. The transitions are:
- IDLE to LOW when enable is sampled high.
- LOW to HIGH after the last low cycle.
- HIGH to LOW after the last counted high cycle.
- any state to IDLE when enable is sampled low.

Top module: `scl_period_gen`

## Requirements
- R1: While reset is asserted, and while enable is low after reset, scl_drive_low, low_start_stb and mid_high_stb are all 0.
- R2: fast_sel = 1 selects fast_hcnt/fast_lcnt, and fast_sel = 0 selects std_hcnt/std_lcnt.
- R3: Each low phase keeps scl_drive_low = 1 for exactly Leff+1 consecutive cycles, where Leff is the selected low count after clamping. low_start_stb is 1 in the first of those cycles only.
- R4: After the low phase, SCL is released. It is driven low again after exactly Heff+8 released cycles in which scl_in is 1, where Heff is the selected high count after clamping.
- R5: A released cycle in which scl_in is 0 (stretching) does not count toward the high phase, and the block keeps SCL released during it.
- R6: A high count below 6 is used as 6, and a low count below 8 is used as 8.
- R7: The counts and fast_sel are captured at every clock edge where enable is 0. Changes to them while enable is 1 do not affect the waveform.
- R8: mid_high_stb is 1 for one cycle per high phase. It falls in the counted high cycle with index floor((Heff+8)/2), counting from 0, and is never 1 at the same time as low_start_stb.
- R9: When enable is sampled 0, scl_drive_low is 0 from the next clock edge on, and stays 0 while enable stays 0.
- R10: When enable is sampled 1 in IDLE, scl_drive_low and low_start_stb become 1 at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator; configuration is captured while low |
| fast_sel | input | 1 | 1 = fast-mode counts, 0 = standard-mode counts |
| std_hcnt | input | CNT_W | Standard-mode high count |
| std_lcnt | input | CNT_W | Standard-mode low count |
| fast_hcnt | input | CNT_W | Fast-mode high count |
| fast_lcnt | input | CNT_W | Fast-mode low count |
| scl_in | input | 1 | Sensed SCL level, synchronous to clk |
| scl_drive_low | output | 1 | 1 = pull SCL low |
| low_start_stb | output | 1 | First cycle of a low phase |
| mid_high_stb | output | 1 | Middle of the counted high time |

## Verification
scl_drive_low is a decode of the state register, so it changes at the first clock edge after the sampled stimulus (enable, end of count). The strobes are decodes of state, counter and scl_in, so they are valid in the same cycle as the phase they mark. The bench drives inputs and samples every output on the falling edge. It measures phase lengths by counting consecutive falling-edge samples of scl_drive_low, so each count matches the rising-edge cycle count exactly. The stretch, enable-drop and configuration-change stimuli are applied on a falling edge, and their effect is checked on the following falling edges.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } scl_state_e;
endpackage

// File: rtl/scl_cfg_capture.sv
`timescale 1ns/1ps
module scl_cfg_capture #(
    parameter int CW   = 16,
    parameter int HMIN = 6,
    parameter int LMIN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          fast_sel,
    input  logic [CW-1:0] std_h,
    input  logic [CW-1:0] std_l,
    input  logic [CW-1:0] fast_h,
    input  logic [CW-1:0] fast_l,
    output logic [CW-1:0] hcnt_eff,
    output logic [CW-1:0] lcnt_eff
);
    localparam logic [CW-1:0] H_FLOOR = CW'(HMIN);
    localparam logic [CW-1:0] L_FLOOR = CW'(LMIN);

    logic          sh_fast;
    logic [CW-1:0] sh_std_h, sh_std_l, sh_fast_h, sh_fast_l;
    logic [CW-1:0] sel_h, sel_l;

    // capture only while the generator is stopped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_fast   <= 1'b0;
            sh_std_h  <= '0;
            sh_std_l  <= '0;
            sh_fast_h <= '0;
            sh_fast_l <= '0;
        end else if (!enable) begin
            sh_fast   <= fast_sel;
            sh_std_h  <= std_h;
            sh_std_l  <= std_l;
            sh_fast_h <= fast_h;
            sh_fast_l <= fast_l;
        end
    end

    always_comb begin
        sel_h    = sh_fast ? sh_fast_h : sh_std_h;
        sel_l    = sh_fast ? sh_fast_l : sh_std_l;
        hcnt_eff = (sel_h < H_FLOOR) ? H_FLOOR : sel_h;
        lcnt_eff = (sel_l < L_FLOOR) ? L_FLOOR : sel_l;
    end

    AST_CFG_HELD_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> ($stable(hcnt_eff) && $stable(lcnt_eff))); // R7
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CW   = 16,
    parameter int HOVH = 8,
    parameter int LOVH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             scl_in,
    input  logic [CW-1:0]    hcnt_eff,
    input  logic [CW-1:0]    lcnt_eff,
    output scl_state_e       state,
    output logic [CW+3:0]    cnt
);
    localparam int NW = CW + 4;
    localparam logic [NW-1:0] H_ADD = NW'(HOVH - 1);
    localparam logic [NW-1:0] L_ADD = NW'(LOVH - 1);
    localparam logic [NW-1:0] ONE   = NW'(1);

    scl_state_e    state_nx;
    logic [NW-1:0] cnt_nx;
    logic [NW-1:0] hi_last, lo_last;

    assign hi_last = NW'(hcnt_eff) + H_ADD;
    assign lo_last = NW'(lcnt_eff) + L_ADD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!enable) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_LOW;
                    cnt_nx   = '0;
                end
                ST_LOW: begin
                    if (cnt == lo_last) begin
                        state_nx = ST_HIGH;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
                ST_HIGH: begin
                    if (scl_in) begin
                        if (cnt == hi_last) begin
                            state_nx = ST_LOW;
                            cnt_nx   = '0;
                        end else begin
                            cnt_nx = cnt + ONE;
                        end
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    AST_LOW_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW) |-> (cnt <= lo_last)); // R3
    AST_HIGH_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> (cnt <= hi_last)); // R4
    AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_HIGH && !scl_in) |=> (state == ST_HIGH && $stable(cnt))); // R5
endmodule

// File: rtl/scl_phase_out.sv
`timescale 1ns/1ps
module scl_phase_out
    import scl_gen_pkg::*;
#(
    parameter int CW   = 16,
    parameter int HOVH = 8
) (
    input  scl_state_e    state,
    input  logic [CW+3:0] cnt,
    input  logic          scl_in,
    input  logic [CW-1:0] hcnt_eff,
    output logic          drive_low,
    output logic          low_start,
    output logic          mid_high
);
    localparam int NW = CW + 4;

    logic [NW-1:0] mid_idx;

    assign mid_idx = (NW'(hcnt_eff) + NW'(HOVH)) >> 1;

    always_comb begin
        drive_low = 1'b0;
        low_start = 1'b0;
        mid_high  = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOW: begin
                drive_low = 1'b1;
                low_start = (cnt == '0);
            end
            ST_HIGH: begin
                mid_high = scl_in && (cnt == mid_idx);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scl_period_gen.sv
`timescale 1ns/1ps
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int HCNT_MIN  = 6,
    parameter int LCNT_MIN  = 8,
    parameter int HIGH_OVHD = 8,
    parameter int LOW_OVHD  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_hcnt,
    input  logic [CNT_W-1:0] std_lcnt,
    input  logic [CNT_W-1:0] fast_hcnt,
    input  logic [CNT_W-1:0] fast_lcnt,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             low_start_stb,
    output logic             mid_high_stb
);
    localparam int NW = CNT_W + 4;

    logic [CNT_W-1:0] hcnt_eff, lcnt_eff;
    scl_state_e       state;
    logic [NW-1:0]    cnt;

    scl_cfg_capture #(.CW(CNT_W), .HMIN(HCNT_MIN), .LMIN(LCNT_MIN)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .fast_sel (fast_sel),
        .std_h    (std_hcnt),
        .std_l    (std_lcnt),
        .fast_h   (fast_hcnt),
        .fast_l   (fast_lcnt),
        .hcnt_eff (hcnt_eff),
        .lcnt_eff (lcnt_eff)
    );

    scl_phase_fsm #(.CW(CNT_W), .HOVH(HIGH_OVHD), .LOVH(LOW_OVHD)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .scl_in   (scl_in),
        .hcnt_eff (hcnt_eff),
        .lcnt_eff (lcnt_eff),
        .state    (state),
        .cnt      (cnt)
    );

    scl_phase_out #(.CW(CNT_W), .HOVH(HIGH_OVHD)) u_out (
        .state     (state),
        .cnt       (cnt),
        .scl_in    (scl_in),
        .hcnt_eff  (hcnt_eff),
        .drive_low (scl_drive_low),
        .low_start (low_start_stb),
        .mid_high  (mid_high_stb)
    );

    AST_RELEASE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_drive_low); // R9
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start_stb, mid_high_stb})); // R8
    AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        low_start_stb |-> (scl_drive_low && !$past(scl_drive_low))); // R3
    AST_FIRST_LOW_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_IDLE) |=> low_start_stb); // R10
endmodule

// File: tb/scl_period_gen_tb.sv
`timescale 1ns/1ps
module scl_period_gen_tb;
    localparam int CW = 16;
    // columns: fast_sel, std_h, std_l, fast_h, fast_l, exp_low, exp_high, exp_mid
    localparam int NV = 8;
    localparam int VEC [NV][8] = '{
        '{0,  10,  12, 20, 30,  13,  18,  9},   // R2 standard pair
        '{1,  10,  12, 20, 30,  31,  28, 14},   // R2 fast pair
        '{0,   2,   3, 20, 30,   9,  14,  7},   // R6 clamp standard
        '{0,   6,   8, 20, 30,   9,  14,  7},   // R6 exactly at minimum
        '{0,   5,   7, 20, 30,   9,  14,  7},   // R6 one below minimum
        '{1,  10,  12,  7,  9,  10,  15,  7},   // R2 fast small
        '{1,  10,  12,  0,  0,   9,  14,  7},   // R6 clamp fast zero
        '{0, 100, 150, 20, 30, 151, 108, 54}    // long periods
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic fast_sel = 1'b0;
    logic [CW-1:0] std_hcnt = '0, std_lcnt = '0, fast_hcnt = '0, fast_lcnt = '0;
    logic stretch = 1'b0;
    logic scl_in;
    logic drv, lsb, msb;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    assign scl_in = ~drv & ~stretch;

    scl_period_gen #(.CNT_W(CW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .fast_sel      (fast_sel),
        .std_hcnt      (std_hcnt),
        .std_lcnt      (std_lcnt),
        .fast_hcnt     (fast_hcnt),
        .fast_lcnt     (fast_lcnt),
        .scl_in        (scl_in),
        .scl_drive_low (drv),
        .low_start_stb (lsb),
        .mid_high_stb  (msb)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // caller stands on a falling edge; measures one full low+high period
    task automatic measure(output int lo, output int hi, output int mid, output int start_ok);
        lo = 0; hi = 0; mid = -1; start_ok = 0;
        while (!drv) @(negedge clk);
        start_ok = lsb ? 1 : 0;
        while (drv) begin
            lo++;
            @(negedge clk);
        end
        while (!drv) begin
            if (msb) mid = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic program_regs(input int m, input int sh, input int sl, input int fh, input int fl);
        fast_sel  = m[0];
        std_hcnt  = CW'(sh);
        std_lcnt  = CW'(sl);
        fast_hcnt = CW'(fh);
        fast_lcnt = CW'(fl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lo, hi, mid, st, rel, ones;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 drive in reset", int'(drv), 0);
        check("R1 low strobe in reset", int'(lsb), 0);
        check("R1 mid strobe in reset", int'(msb), 0);
        rst_n = 1'b1;
        ones = 0;
        repeat (10) begin
            @(negedge clk);
            ones += int'(drv) + int'(lsb) + int'(msb);
        end
        check("R1 idle outputs while disabled", ones, 0);

        // table of vectors: R2 R3 R4 R6 R8
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            enable = 1'b0;
            program_regs(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
            repeat (2) @(negedge clk);
            enable = 1'b1;
            for (int p = 0; p < 2; p++) begin
                measure(lo, hi, mid, st);
                check($sformatf("R3 low length vec%0d", v), lo, VEC[v][5]);
                check($sformatf("R4 high length vec%0d", v), hi, VEC[v][6]);
                check($sformatf("R8 mid strobe index vec%0d", v), mid, VEC[v][7]);
                check($sformatf("R3 low start strobe vec%0d", v), st, 1);
            end
        end

        // R10: first drive low at the edge that samples enable
        @(negedge clk);
        enable = 1'b0;
        program_regs(0, 10, 12, 20, 30);
        repeat (3) @(negedge clk);
        check("R10 released before enable", int'(drv), 0);
        enable = 1'b1;
        @(negedge clk);
        check("R10 drive low one edge after enable", int'(drv), 1);
        check("R10 low strobe one edge after enable", int'(lsb), 1);

        // R9: dropping enable releases at the next edge and stays released
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R9 released after disable", int'(drv), 0);
        ones = 0;
        repeat (40) begin
            @(negedge clk);
            ones += int'(drv);
        end
        check("R9 stays released while disabled", ones, 0);

        // R7: changes while running are ignored
        program_regs(0, 10, 12, 20, 30);
        @(negedge clk);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        program_regs(1, 40, 50, 60, 70);
        measure(lo, hi, mid, st);    // partial period, discarded
        measure(lo, hi, mid, st);
        check("R7 low length unchanged while running", lo, 13);
        check("R7 high length unchanged while running", hi, 18);

        // R5: stretch 5 cycles at the start of the high phase
        while (drv) @(negedge clk);
        while (!drv) @(negedge clk);
        while (drv) @(negedge clk);
        stretch = 1'b1;
        rel = 0;
        ones = 0;
        repeat (5) begin
            rel++;
            ones += int'(drv) + int'(msb);
            @(negedge clk);
        end
        stretch = 1'b0;
        while (!drv) begin
            rel++;
            @(negedge clk);
        end
        check("R5 no drive or mid strobe during stretch", ones, 0);
        check("R5 released cycles with stretch", rel, 23);
        measure(lo, hi, mid, st);
        check("R5 next high after stretch", hi, 18);

        // R7: the new values take effect after a disabled interval
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        measure(lo, hi, mid, st);
        check("R7 new fast low length after disable", lo, 71);
        check("R7 new fast high length after disable", hi, 68);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule